// File: doc/BRIEF.md
# Loop-Bandwidth Calibration Sequencer

This block runs the open-loop calibration that keeps a charge-pump PLL's loop bandwidth constant across a wide tuning range. It starts after the capacitor-bank code has been fixed. It first moves the oscillator's tuning voltage to a low point, waits a programmable settling time and asks the frequency counter for a count. It then moves the tuning voltage to a high point and takes a second count. Both counts are held in registers.

The tuning-voltage step between the two points is fixed, so the difference of the two counts stands in for the oscillator gain. The loop bandwidth scales with charge-pump current × gain / division ratio. To hold that product constant, the block computes a current code inversely proportional to the measured gain: round(K × N / Δcount). K is a bandwidth target constant and N is the division ratio. The division is done with a sequential restoring divider.

The result is clamped into a 7-bit code range of 1 to 127. A measurement with no positive frequency rise forces the largest code and raises an error flag.

Top module: `lbw_cal_top`

## Requirements
- R1: After reset, vtune_sel_o, cnt_start_o, cp_code_o, done_o and err_o are all 0.
- R2: The first count is requested with vtune_sel_o = 0 (low tuning point) and the second with vtune_sel_o = 1 (high tuning point). vtune_sel_o stays constant from each count request until that count's cnt_done_i.
- R3: cnt_start_o goes high at the (S+1)-th rising edge after the edge that samples start_i or the low-point cnt_done_i, where S is settle_i.
- R4: cnt_start_o is a single-cycle pulse, and it is issued exactly once per tuning point.
- R5: With Δ = high count − low count > 0, cp_code_o = floor((2·K·N + Δ) / (2·Δ)), which is K·N/Δ rounded with halves going up.
- R6: A rounded quotient above 127 yields cp_code_o = 127 with err_o = 0.
- R7: A rounded quotient of 0 yields cp_code_o = 1.
- R8: If the high count is not greater than the low count, cp_code_o = 127 and err_o = 1.
- R9: done_o rises when the result is ready. done_o, cp_code_o and err_o then hold until the next start_i. A start_i during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin calibration; honoured only when idle or done |
| div_ratio_i | input | 12 | Integer division ratio N, sampled at start |
| bw_const_i | input | 16 | Bandwidth target constant K, sampled at start |
| settle_i | input | 8 | Settling delay in reference cycles after each tuning change |
| cnt_val_i | input | 16 | Frequency count result |
| cnt_done_i | input | 1 | Count result valid (one cycle) |
| vtune_sel_o | output | 1 | Tuning point select: 0 low, 1 high |
| cnt_start_o | output | 1 | Count request pulse |
| cp_code_o | output | 7 | Charge-pump current code |
| done_o | output | 1 | Calibration complete |
| err_o | output | 1 | No positive gain measured |

## Verification
Assertions check on every cycle the following properties:
- the count request is a one-cycle pulse;
- the tuning select holds while a count is pending;
- a finished code is never zero;
- an error always comes with the maximum code;
- a finished result stays still;
- the divider's quotient and remainder are consistent with its operands.

Only the bench's scenarios can show the remaining behaviour:
- the exact settling latency;
- the low-then-high ordering;
- the rounding at the half point and below it;
- both saturation limits;
- the zero and negative gain cases;
- immunity to a start pulse in mid-run.

// File: rtl/lbw_cal_pkg.sv
package lbw_cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SET_LO,
    ST_CNT_LO,
    ST_SET_HI,
    ST_CNT_HI,
    ST_DIV,
    ST_DONE
  } cal_state_e;
endpackage

// File: rtl/lbw_settle_timer.sv
module lbw_settle_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  a_r3_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/lbw_seq_div.sv
module lbw_seq_div #(
  parameter int unsigned NUM_W = 30,
  parameter int unsigned DEN_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [NUM_W-1:0] dend_i,
  input  logic [DEN_W-1:0] dsor_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int unsigned IT_W = $clog2(NUM_W + 1);
  localparam int unsigned PW   = NUM_W + DEN_W;

  logic             busy_q, done_q;
  logic [IT_W-1:0]  it_q;
  logic [DEN_W:0]   rem_q;
  logic [NUM_W-1:0] quo_q, dend_q;
  logic [DEN_W-1:0] dsor_q;
  logic [DEN_W:0]   shifted;
  logic             fits;

  assign shifted = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
  assign fits    = (shifted >= {1'b0, dsor_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      it_q   <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dend_q <= '0;
      dsor_q <= '0;
    end else if (go_i) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      it_q   <= IT_W'(NUM_W);
      rem_q  <= '0;
      quo_q  <= dend_i;
      dend_q <= dend_i;
      dsor_q <= dsor_i;
    end else if (busy_q) begin
      rem_q  <= fits ? (shifted - {1'b0, dsor_q}) : shifted;
      quo_q  <= {quo_q[NUM_W-2:0], fits};
      it_q   <= it_q - 1'b1;
      if (it_q == IT_W'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;

  a_r5_div_lower: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && dsor_q != '0) |-> (PW'(quo_q) * PW'(dsor_q) <= PW'(dend_q)));
  a_r5_div_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && dsor_q != '0) |-> (PW'(dend_q) - PW'(quo_q) * PW'(dsor_q) < PW'(dsor_q)));
  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/lbw_code_clamp.sv
module lbw_code_clamp #(
  parameter int unsigned NUM_W  = 30,
  parameter int unsigned CODE_W = 7
) (
  input  logic [NUM_W-1:0]  quo_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  always_comb begin
    if (quo_i > NUM_W'(CODE_MAX))  code_o = CODE_MAX;
    else if (quo_i == '0)          code_o = CODE_W'(1);
    else                           code_o = quo_i[CODE_W-1:0];
  end
endmodule

// File: rtl/lbw_cal_top.sv
module lbw_cal_top
  import lbw_cal_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DIV_W    = 12,
  parameter int unsigned K_W      = 16,
  parameter int unsigned SETTLE_W = 8,
  parameter int unsigned CODE_W   = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [DIV_W-1:0]    div_ratio_i,
  input  logic [K_W-1:0]      bw_const_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [CNT_W-1:0]    cnt_val_i,
  input  logic                cnt_done_i,
  output logic                vtune_sel_o,
  output logic                cnt_start_o,
  output logic [CODE_W-1:0]   cp_code_o,
  output logic                done_o,
  output logic                err_o
);
  localparam int unsigned KN_W  = K_W + DIV_W;
  localparam int unsigned NUM_W = KN_W + 2;
  localparam int unsigned DEN_W = CNT_W + 1;
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  cal_state_e        state_q;
  logic [K_W-1:0]    k_q;
  logic [DIV_W-1:0]  n_q;
  logic [CNT_W-1:0]  lo_q, hi_q;
  logic              vtune_q, start_q, done_q, err_q, div_go_q;
  logic [CODE_W-1:0] code_q;

  logic              tmr_load, tmr_expired;
  logic [CNT_W-1:0]  delta;
  logic [KN_W-1:0]   kn;
  logic [NUM_W-1:0]  dend;
  logic [DEN_W-1:0]  dsor;
  logic              div_done;
  logic [NUM_W-1:0]  quo;
  logic [CODE_W-1:0] code_clamped;
  logic              accept;

  assign accept   = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign tmr_load = accept || (state_q == ST_CNT_LO && cnt_done_i);

  lbw_settle_timer #(.W(SETTLE_W)) settle_i0 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .len_i     (settle_i),
    .expired_o (tmr_expired)
  );

  assign delta = hi_q - lo_q;
  assign kn    = {{DIV_W{1'b0}}, k_q} * {{K_W{1'b0}}, n_q};
  assign dend  = {1'b0, kn, 1'b0} + NUM_W'(delta);
  assign dsor  = {delta, 1'b0};

  lbw_seq_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) div_i0 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (div_go_q),
    .dend_i (dend),
    .dsor_i (dsor),
    .done_o (div_done),
    .quo_o  (quo)
  );

  lbw_code_clamp #(.NUM_W(NUM_W), .CODE_W(CODE_W)) clamp_i0 (
    .quo_i  (quo),
    .code_o (code_clamped)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      k_q      <= '0;
      n_q      <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      vtune_q  <= 1'b0;
      start_q  <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      div_go_q <= 1'b0;
      code_q   <= '0;
    end else begin
      start_q  <= 1'b0;
      div_go_q <= 1'b0;
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (accept) begin
            k_q     <= bw_const_i;
            n_q     <= div_ratio_i;
            vtune_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            state_q <= ST_SET_LO;
          end
        end
        ST_SET_LO: begin
          if (tmr_expired) begin
            start_q <= 1'b1;
            state_q <= ST_CNT_LO;
          end
        end
        ST_CNT_LO: begin
          if (cnt_done_i) begin
            lo_q    <= cnt_val_i;
            vtune_q <= 1'b1;
            state_q <= ST_SET_HI;
          end
        end
        ST_SET_HI: begin
          if (tmr_expired) begin
            start_q <= 1'b1;
            state_q <= ST_CNT_HI;
          end
        end
        ST_CNT_HI: begin
          if (cnt_done_i) begin
            hi_q <= cnt_val_i;
            if (cnt_val_i > lo_q) begin
              div_go_q <= 1'b1;
              state_q  <= ST_DIV;
            end else begin
              // no positive gain: widest current, flag it
              code_q  <= CODE_MAX;
              err_q   <= 1'b1;
              done_q  <= 1'b1;
              state_q <= ST_DONE;
            end
          end
        end
        ST_DIV: begin
          if (div_done) begin
            code_q  <= code_clamped;
            done_q  <= 1'b1;
            state_q <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign vtune_sel_o = vtune_q;
  assign cnt_start_o = start_q;
  assign cp_code_o   = code_q;
  assign done_o      = done_q;
  assign err_o       = err_q;

  a_r4_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_start_o |=> !cnt_start_o);
  a_r2_vtune_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_start_o |=> $stable(vtune_sel_o));
  a_r7_code_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cp_code_o != '0));
  a_r8_err_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (done_o && cp_code_o == CODE_MAX));
  a_r9_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(cp_code_o) && $stable(err_o)));
  a_r4_no_start_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_start_o |-> !done_o);
endmodule

// File: tb/lbw_cal_top_tb.sv
module lbw_cal_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] div_ratio = '0;
  logic [15:0] bw_const = '0;
  logic [7:0]  settle = '0;
  logic [15:0] cnt_val = '0;
  logic        cnt_done = 1'b0;
  logic        vtune_sel, cnt_start, done, err;
  logic [6:0]  cp_code;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  lbw_cal_top dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .div_ratio_i (div_ratio),
    .bw_const_i  (bw_const),
    .settle_i    (settle),
    .cnt_val_i   (cnt_val),
    .cnt_done_i  (cnt_done),
    .vtune_sel_o (vtune_sel),
    .cnt_start_o (cnt_start),
    .cp_code_o   (cp_code),
    .done_o      (done),
    .err_o       (err)
  );

  typedef struct packed {
    logic [15:0] k;
    logic [11:0] n;
    logic [15:0] lo;
    logic [15:0] hi;
    logic [7:0]  settle;
    logic [6:0]  code;
    logic        err;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'd1000, 12'd100, 16'd5000, 16'd6000,  8'd0, 7'd100, 1'b0}, // R5
    '{16'd300,  12'd50,  16'd1000, 16'd1400,  8'd3, 7'd38,  1'b0}, // R5 37.5 up
    '{16'd7,    12'd3,   16'd10,   16'd20,    8'd1, 7'd2,   1'b0}, // R5
    '{16'd5,    12'd1,   16'd40,   16'd42,    8'd1, 7'd3,   1'b0}, // R5 2.5 up
    '{16'd9,    12'd1,   16'd60,   16'd64,    8'd2, 7'd2,   1'b0}, // R5 2.25 down
    '{16'd254,  12'd1,   16'd500,  16'd502,   8'd0, 7'd127, 1'b0}, // R6 edge exact
    '{16'd256,  12'd1,   16'd500,  16'd502,   8'd4, 7'd127, 1'b0}, // R6 128 sat
    '{16'd2000, 12'd200, 16'd0,    16'd100,   8'd5, 7'd127, 1'b0}, // R6
    '{16'd10,   12'd10,  16'd100,  16'd10100, 8'd2, 7'd1,   1'b0}, // R7
    '{16'd50,   12'd40,  16'd800,  16'd800,   8'd2, 7'd127, 1'b1}, // R8 zero
    '{16'd50,   12'd40,  16'd900,  16'd800,   8'd0, 7'd127, 1'b1}  // R8 negative
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // wait for cnt_start, counting rising edges since the last negedge
  task automatic wait_start(output int edges);
    edges = 0;
    while (!cnt_start && edges < 600) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
    end
  endtask

  task automatic answer(input logic [15:0] v);
    @(negedge clk);
    check(!cnt_start, "R4 pulse width", int'(cnt_start), 0);
    repeat (2) @(negedge clk);
    cnt_val  = v;
    cnt_done = 1'b1;
    @(negedge clk);
    cnt_done = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input bit stray_start);
    int e;
    bw_const  = v.k;
    div_ratio = v.n;
    settle    = v.settle;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(!done, "R9 done cleared", int'(done), 0);
    wait_start(e);
    check(e == int'(v.settle) + 1, "R3 settle low", e, int'(v.settle) + 1);
    check(vtune_sel == 1'b0, "R2 low first", int'(vtune_sel), 0);
    if (stray_start) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cnt_val  = v.lo;
      cnt_done = 1'b1;
      @(negedge clk);
      cnt_done = 1'b0;
    end else begin
      answer(v.lo);
    end
    wait_start(e);
    check(e == int'(v.settle) + 1, "R3 settle high", e, int'(v.settle) + 1);
    check(vtune_sel == 1'b1, "R2 high second", int'(vtune_sel), 1);
    answer(v.hi);
    e = 0;
    while (!done && e < 200) begin
      @(negedge clk);
      e++;
      if (cnt_start) check(0, "R4 extra start", 1, 0);
    end
    check(done, "R9 done", int'(done), 1);
    check(cp_code == v.code, "R5/R6/R7/R8 code", int'(cp_code), int'(v.code));
    check(err == v.err, "R8 err", int'(err), int'(v.err));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    check(vtune_sel == 0 && cnt_start == 0 && cp_code == 0 && done == 0 && err == 0,
          "R1 reset outputs", int'({vtune_sel, cnt_start, cp_code, done, err}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!cnt_start && !done, "R1 idle after reset", int'({cnt_start, done}), 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

    // R9: stray start mid-run ignored
    run_vec(VECS[1], 1'b1);

    // R9: result holds while inputs change
    cnt_val   = 16'hffff;
    cnt_done  = 1'b1;
    bw_const  = 16'd1;
    div_ratio = 12'd1;
    repeat (20) @(negedge clk);
    cnt_done = 1'b0;
    check(done && cp_code == 7'd38 && !err, "R9 hold", int'(cp_code), 38);
    check(!cnt_start, "R4 no start when done", int'(cnt_start), 0);

    // R8 then normal run: err must clear
    run_vec(VECS[9], 1'b0);
    run_vec(VECS[0], 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule